// File: doc/BRIEF.md
# Four-Lane Word/Byte Data Buffer

This block holds the data that moves between a register interface and a serial engine. It is built from four byte-wide lanes, each a 16-entry first-in first-out queue. A 32-bit access touches all four lanes in one cycle, so word traffic sees 64 bytes of room. A byte access touches lane 0 alone, so byte traffic sees 16 bytes. The transmit half takes pushes from the register side and gives bytes to the serial side. The receive half takes bytes from the serial side and gives words or bytes to the register side.

A single mode input, `ser_wide`, sets how the serial side walks the lanes. When it is high, the serial side visits lanes 0, 1, 2, 3 in turn, which matches the byte order of word accesses. When it is low, the serial side uses lane 0 only, which matches byte accesses. Status flags are reported for both access widths, so software can choose its access size and check the flag that fits it. Pushes that find no room are dropped and reported on a one-cycle overflow pulse.

Top module: `quad_lane_buffer`

## Requirements
- R1: After reset every lane is empty, all full, half, available, valid and overflow outputs are 0, and `rx_rdata` and `tx_ser_data` are 0.
- R2: A transmit word push stores bits [8k+7:8k] of `tx_wdata` in lane k. With `ser_wide`=1 the serial side pops lanes in the order 0,1,2,3 and then repeats, advancing only on a successful pop. The serial lane pointer returns to lane 0 while `ser_wide`=0.
- R3: A transmit byte push stores `tx_wdata[7:0]` in lane 0. With `ser_wide`=0 the serial side presents and pops lane 0 only, and lanes 1 to 3 are left untouched.
- R4: `tx_full_word` is 1 when any transmit lane holds 16 bytes, so 16 word pushes (64 bytes) fill it. `tx_full_byte` is 1 when lane 0 holds 16 bytes.
- R5: `tx_half_word` is 1 when the four transmit lanes together hold at least 32 bytes. `tx_half_byte` is 1 when transmit lane 0 holds at least 8 bytes.
- R6: A transmit push that finds its target full is dropped and leaves every lane unchanged. `tx_ovf` is then 1 for exactly the one cycle after that clock edge.
- R7: A serial receive push goes to the lane chosen by the same walk as in R2 and R3. A push into a full lane is dropped, does not advance the walk, and raises `rx_ovf` for one cycle after the edge.
- R8: `rx_avail_word` is 1 when all four receive lanes hold data. A word pop then returns {lane3, lane2, lane1, lane0} heads on `rx_rdata` in the same cycle and removes one byte from each lane. `rx_avail_byte` is 1 when lane 0 holds data. A byte pop returns the lane-0 head zero-extended to 32 bits.
- R9: A pop with no data available returns zero (`tx_ser_valid`=0, `tx_ser_data`=0, or `rx_rdata`=0) and moves no pointer.
- R10: When a word request and a byte request arrive in the same cycle, on either side, the word request is served and the byte request is ignored.
- R11: Each lane keeps first-in first-out order. A push and a pop on the same non-empty lane in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_wide | input | 1 | Serial side walks all lanes (1) or lane 0 only (0) |
| tx_push_word | input | 1 | Register side pushes a 32-bit word to transmit |
| tx_push_byte | input | 1 | Register side pushes one byte to transmit lane 0 |
| tx_wdata | input | 32 | Transmit push data |
| tx_full_word | output | 1 | No room for a word push |
| tx_full_byte | output | 1 | No room for a byte push |
| tx_half_word | output | 1 | Transmit holds at least half of its word capacity |
| tx_half_byte | output | 1 | Transmit lane 0 is at least half full |
| tx_ovf | output | 1 | Pulse: a transmit push was dropped |
| tx_ser_pop | input | 1 | Serial side takes the presented byte |
| tx_ser_valid | output | 1 | A transmit byte is presented |
| tx_ser_data | output | 8 | Presented transmit byte |
| rx_ser_push | input | 1 | Serial side delivers a received byte |
| rx_ser_byte | input | 8 | Received byte |
| rx_ovf | output | 1 | Pulse: a received byte was dropped |
| rx_pop_word | input | 1 | Register side reads a 32-bit word |
| rx_pop_byte | input | 1 | Register side reads one byte from lane 0 |
| rx_rdata | output | 32 | Receive read data, valid in the pop cycle |
| rx_avail_word | output | 1 | At least one full word can be read |
| rx_avail_byte | output | 1 | At least one byte can be read |

## Verification
The bench targets the edges of the two capacities. It fills the transmit side with exactly 16 words and then tries a 17th. A design that checked only lane 0, or tracked a shared byte count, would flag full too late or too early, and it would corrupt data or miss the overflow pulse. Uneven lane levels come from switching `ser_wide` part way through a drain. These catch a serial walk that does not stop on an empty lane or does not return to lane 0, since such a design emits bytes out of order. Dual requests, a push and pop on one lane in the same cycle, and pops on empty queues are driven directly. A wrong priority, a lost simultaneous push, or non-zero data on empty reads each show up as a data mismatch against the bench's per-lane queue model.

// File: rtl/qlb_pkg.sv
package qlb_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = LANES * BYTE_W;
    localparam int unsigned SEL_W  = $clog2(LANES);
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SEL_W-1:0]  lane_sel_t;
endpackage

// File: rtl/qlb_lane.sv
module qlb_lane
    import qlb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  byte_t         data_i,
    input  logic          pop_i,
    output byte_t         head_o,
    output logic [CW-1:0] count_o,
    output logic          empty_o,
    output logic          full_o
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [AW-1:0]                wr;
        logic [AW-1:0]                rd;
        logic [CW-1:0]                cnt;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic do_push, do_pop;

    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign count_o = st_q.cnt;
    assign head_o  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr           = st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Occupancy never goes past the lane depth (capacity, R4)
    assert_lane_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    // A push into a full lane leaves the level unchanged (R6)
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> (count_o == $past(count_o)));

    // A pop from an empty lane moves nothing (R9)
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/qlb_tx_path.sv
module qlb_tx_path
    import qlb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH) + 1,
    localparam int unsigned TW = $clog2(LANES * DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_wide_i,
    input  logic              push_word_i,
    input  logic              push_byte_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              full_word_o,
    output logic              full_byte_o,
    output logic              half_word_o,
    output logic              half_byte_o,
    output logic              ovf_o,
    input  logic              ser_pop_i,
    output logic              ser_valid_o,
    output byte_t             ser_data_o
);
    typedef struct packed {
        lane_sel_t ptr;
        logic      ovf;
    } tx_st_t;

    tx_st_t st_d, st_q;

    logic          lane_push  [LANES];
    byte_t         lane_din   [LANES];
    logic          lane_pop   [LANES];
    byte_t         lane_head  [LANES];
    logic [CW-1:0] lane_cnt   [LANES];
    logic          lane_empty [LANES];
    logic          lane_full  [LANES];

    logic      word_blocked, word_ok, byte_ok, valid;
    lane_sel_t sel;
    logic [TW-1:0] total;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qlb_lane #(.DEPTH(DEPTH)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (lane_push[g]),
            .data_i  (lane_din[g]),
            .pop_i   (lane_pop[g]),
            .head_o  (lane_head[g]),
            .count_o (lane_cnt[g]),
            .empty_o (lane_empty[g]),
            .full_o  (lane_full[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        word_blocked = 1'b0;
        total        = '0;
        for (int i = 0; i < LANES; i++) begin
            word_blocked = word_blocked | lane_full[i];
            total        = total + TW'(lane_cnt[i]);
        end
        word_ok  = push_word_i && !word_blocked;
        byte_ok  = push_byte_i && !push_word_i && !lane_full[0];
        st_d.ovf = (push_word_i && word_blocked) ||
                   (push_byte_i && !push_word_i && lane_full[0]);
        sel   = ser_wide_i ? st_q.ptr : '0;
        valid = !lane_empty[sel];
        for (int i = 0; i < LANES; i++) begin
            lane_push[i] = word_ok || ((i == 0) && byte_ok);
            lane_din[i]  = word_ok ? wdata_i[i*BYTE_W +: BYTE_W] : wdata_i[BYTE_W-1:0];
            lane_pop[i]  = ser_pop_i && valid && (sel == SEL_W'(i));
        end
        if (!ser_wide_i)
            st_d.ptr = '0;
        else if (ser_pop_i && valid)
            st_d.ptr = st_q.ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_word_o = word_blocked;
    assign full_byte_o = lane_full[0];
    assign half_word_o = (total >= TW'(LANES * DEPTH / 2));
    assign half_byte_o = (lane_cnt[0] >= CW'(DEPTH / 2));
    assign ovf_o       = st_q.ovf;
    assign ser_valid_o = valid;
    assign ser_data_o  = valid ? lane_head[sel] : '0;

    // Narrow serial mode and byte pushes never touch the upper lanes (R3)
    for (genvar g = 1; g < LANES; g++) begin : g_chk
        assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ser_wide_i && !push_word_i) |=> $stable(lane_cnt[g]));
    end

    // An overflow pulse only follows a cycle in which a full flag was set (R6)
    assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(full_word_o || full_byte_o));
endmodule

// File: rtl/qlb_rx_path.sv
module qlb_rx_path
    import qlb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_wide_i,
    input  logic              ser_push_i,
    input  byte_t             ser_byte_i,
    output logic              ovf_o,
    input  logic              pop_word_i,
    input  logic              pop_byte_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              avail_word_o,
    output logic              avail_byte_o
);
    typedef struct packed {
        lane_sel_t ptr;
        logic      ovf;
    } rx_st_t;

    rx_st_t st_d, st_q;

    logic          lane_push  [LANES];
    logic          lane_pop   [LANES];
    byte_t         lane_head  [LANES];
    logic [CW-1:0] lane_cnt   [LANES];
    logic          lane_empty [LANES];
    logic          lane_full  [LANES];

    logic      push_ok, word_ok, byte_ok, all_ready;
    lane_sel_t sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qlb_lane #(.DEPTH(DEPTH)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (lane_push[g]),
            .data_i  (ser_byte_i),
            .pop_i   (lane_pop[g]),
            .head_o  (lane_head[g]),
            .count_o (lane_cnt[g]),
            .empty_o (lane_empty[g]),
            .full_o  (lane_full[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        all_ready = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            all_ready = all_ready & !lane_empty[i];
        end
        sel      = ser_wide_i ? st_q.ptr : '0;
        push_ok  = ser_push_i && !lane_full[sel];
        st_d.ovf = ser_push_i && lane_full[sel];
        word_ok  = pop_word_i && all_ready;
        byte_ok  = pop_byte_i && !pop_word_i && !lane_empty[0];
        rdata_o  = '0;
        for (int i = 0; i < LANES; i++) begin
            lane_push[i] = push_ok && (sel == SEL_W'(i));
            lane_pop[i]  = word_ok || ((i == 0) && byte_ok);
            if (word_ok) rdata_o[i*BYTE_W +: BYTE_W] = lane_head[i];
        end
        if (byte_ok) rdata_o[BYTE_W-1:0] = lane_head[0];
        if (!ser_wide_i)
            st_d.ptr = '0;
        else if (push_ok)
            st_d.ptr = st_q.ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_o        = st_q.ovf;
    assign avail_word_o = all_ready;
    assign avail_byte_o = !lane_empty[0];

    // A readable word implies a readable byte (R8)
    assert_word_has_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        avail_word_o |-> avail_byte_o);

    // Dropped serial byte is reported only when its target lane was full (R7)
    assert_rx_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(ser_push_i));
endmodule

// File: rtl/quad_lane_buffer.sv
module quad_lane_buffer
    import qlb_pkg::*;
#(
    parameter int unsigned LANE_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_wide,
    input  logic        tx_push_word,
    input  logic        tx_push_byte,
    input  logic [31:0] tx_wdata,
    output logic        tx_full_word,
    output logic        tx_full_byte,
    output logic        tx_half_word,
    output logic        tx_half_byte,
    output logic        tx_ovf,
    input  logic        tx_ser_pop,
    output logic        tx_ser_valid,
    output logic [7:0]  tx_ser_data,
    input  logic        rx_ser_push,
    input  logic [7:0]  rx_ser_byte,
    output logic        rx_ovf,
    input  logic        rx_pop_word,
    input  logic        rx_pop_byte,
    output logic [31:0] rx_rdata,
    output logic        rx_avail_word,
    output logic        rx_avail_byte
);
    qlb_tx_path #(.DEPTH(LANE_DEPTH)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_wide_i  (ser_wide),
        .push_word_i (tx_push_word),
        .push_byte_i (tx_push_byte),
        .wdata_i     (tx_wdata),
        .full_word_o (tx_full_word),
        .full_byte_o (tx_full_byte),
        .half_word_o (tx_half_word),
        .half_byte_o (tx_half_byte),
        .ovf_o       (tx_ovf),
        .ser_pop_i   (tx_ser_pop),
        .ser_valid_o (tx_ser_valid),
        .ser_data_o  (tx_ser_data)
    );

    qlb_rx_path #(.DEPTH(LANE_DEPTH)) rx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_wide_i   (ser_wide),
        .ser_push_i   (rx_ser_push),
        .ser_byte_i   (rx_ser_byte),
        .ovf_o        (rx_ovf),
        .pop_word_i   (rx_pop_word),
        .pop_byte_i   (rx_pop_byte),
        .rdata_o      (rx_rdata),
        .avail_word_o (rx_avail_word),
        .avail_byte_o (rx_avail_byte)
    );

    // Word full always covers byte full, as lane 0 is one of the word lanes (R4)
    assert_full_nesting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full_byte |-> tx_full_word);
endmodule

// File: tb/quad_lane_buffer_tb_top.sv
`timescale 1ns/1ps
module quad_lane_buffer_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_wide = 1'b0;
    logic        tx_push_word = 1'b0, tx_push_byte = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        tx_full_word, tx_full_byte, tx_half_word, tx_half_byte, tx_ovf;
    logic        tx_ser_pop = 1'b0;
    logic        tx_ser_valid;
    logic [7:0]  tx_ser_data;
    logic        rx_ser_push = 1'b0;
    logic [7:0]  rx_ser_byte = '0;
    logic        rx_ovf;
    logic        rx_pop_word = 1'b0, rx_pop_byte = 1'b0;
    logic [31:0] rx_rdata;
    logic        rx_avail_word, rx_avail_byte;

    always #2.5 clk = ~clk;

    quad_lane_buffer #(.LANE_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_wide(ser_wide),
        .tx_push_word(tx_push_word), .tx_push_byte(tx_push_byte), .tx_wdata(tx_wdata),
        .tx_full_word(tx_full_word), .tx_full_byte(tx_full_byte),
        .tx_half_word(tx_half_word), .tx_half_byte(tx_half_byte), .tx_ovf(tx_ovf),
        .tx_ser_pop(tx_ser_pop), .tx_ser_valid(tx_ser_valid), .tx_ser_data(tx_ser_data),
        .rx_ser_push(rx_ser_push), .rx_ser_byte(rx_ser_byte), .rx_ovf(rx_ovf),
        .rx_pop_word(rx_pop_word), .rx_pop_byte(rx_pop_byte), .rx_rdata(rx_rdata),
        .rx_avail_word(rx_avail_word), .rx_avail_byte(rx_avail_byte)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] tq [4][$];
    logic [7:0] rq [4][$];
    int tptr = 0;
    int rptr = 0;
    bit exp_tovf = 0;
    bit exp_rovf = 0;
    string dtag = "";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit any_full(int lim);
        for (int i = 0; i < 4; i++) if (tq[i].size() >= lim) return 1;
        return 0;
    endfunction

    function automatic int tx_total();
        int s = 0;
        for (int i = 0; i < 4; i++) s += tq[i].size();
        return s;
    endfunction

    // One clock cycle: drive at the falling edge, check, then update the model
    task automatic cyc(bit wide, bit pw, bit pb, logic [31:0] wd, bit sp,
                       bit rpush, logic [7:0] rb, bit rpw, bit rpb);
        int tsel, rsel;
        bit tvalid, fw, fb, wok, bok, rpok, rwok, rbok, allr;
        logic [31:0] exp_rd;
        string tg;
        @(negedge clk);
        ser_wide = wide; tx_push_word = pw; tx_push_byte = pb; tx_wdata = wd;
        tx_ser_pop = sp; rx_ser_push = rpush; rx_ser_byte = rb;
        rx_pop_word = rpw; rx_pop_byte = rpb;
        #1;
        fw = any_full(DEPTH);
        fb = (tq[0].size() == DEPTH);
        chk("R4", "tx_full_word", tx_full_word, fw);
        chk("R4", "tx_full_byte", tx_full_byte, fb);
        chk("R5", "tx_half_word", tx_half_word, tx_total() >= 2*DEPTH);
        chk("R5", "tx_half_byte", tx_half_byte, tq[0].size() >= DEPTH/2);
        chk("R6", "tx_ovf", tx_ovf, exp_tovf);
        chk("R7", "rx_ovf", rx_ovf, exp_rovf);
        tsel = wide ? tptr : 0;
        tvalid = tq[tsel].size() > 0;
        tg = (dtag != "") ? dtag : (!tvalid ? "R9" : (wide ? "R2" : "R3"));
        chk(tg, "tx_ser_valid", tx_ser_valid, tvalid);
        chk(tg, "tx_ser_data", tx_ser_data, tvalid ? tq[tsel][0] : 8'h0);
        allr = 1;
        for (int i = 0; i < 4; i++) if (rq[i].size() == 0) allr = 0;
        chk("R8", "rx_avail_word", rx_avail_word, allr);
        chk("R8", "rx_avail_byte", rx_avail_byte, rq[0].size() > 0);
        rwok = rpw && allr;
        rbok = rpb && !rpw && rq[0].size() > 0;
        exp_rd = 0;
        if (rwok) exp_rd = {rq[3][0], rq[2][0], rq[1][0], rq[0][0]};
        if (rbok) exp_rd = {24'h0, rq[0][0]};
        tg = (dtag != "") ? dtag : ((rpw && rpb) ? "R10" : ((rwok || rbok) ? "R8" : "R9"));
        chk(tg, "rx_rdata", rx_rdata, exp_rd);
        // model update from pre-state decisions
        wok = pw && !fw;
        bok = pb && !pw && !fb;
        exp_tovf = (pw && fw) || (pb && !pw && fb);
        rsel = wide ? rptr : 0;
        rpok = rpush && rq[rsel].size() < DEPTH;
        exp_rovf = rpush && !rpok;
        if (sp && tvalid) void'(tq[tsel].pop_front());
        if (wok) for (int i = 0; i < 4; i++) tq[i].push_back(wd[i*8 +: 8]);
        if (bok) tq[0].push_back(wd[7:0]);
        if (rwok) for (int i = 0; i < 4; i++) void'(rq[i].pop_front());
        if (rbok) void'(rq[0].pop_front());
        if (rpok) rq[rsel].push_back(rb);
        tptr = !wide ? 0 : ((sp && tvalid) ? (tptr + 1) % 4 : tptr);
        rptr = !wide ? 0 : (rpok ? (rptr + 1) % 4 : rptr);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "tx_full_word", tx_full_word, 0);
        chk("R1", "tx_full_byte", tx_full_byte, 0);
        chk("R1", "tx_half_word", tx_half_word, 0);
        chk("R1", "tx_half_byte", tx_half_byte, 0);
        chk("R1", "tx_ovf", tx_ovf, 0);
        chk("R1", "rx_ovf", rx_ovf, 0);
        chk("R1", "tx_ser_valid", tx_ser_valid, 0);
        chk("R1", "tx_ser_data", tx_ser_data, 0);
        chk("R1", "rx_avail_word", rx_avail_word, 0);
        chk("R1", "rx_avail_byte", rx_avail_byte, 0);
        chk("R1", "rx_rdata", rx_rdata, 0);

        // R9: pops on empty queues
        cyc(1, 0, 0, 0, 1, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1);

        // R4 and R6: 16 words fill the transmit side, the 17th is dropped
        for (int k = 0; k < 17; k++)
            cyc(1, 1, 0, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, 0, 0, 0, 0, 0);
        cyc(1, 0, 1, 32'hee, 0, 0, 0, 0, 0);  // byte push also dropped (R6)
        idle();
        // R2: drain all 64 bytes in lane order
        for (int k = 0; k < 65; k++) cyc(1, 0, 0, 0, 1, 0, 0, 0, 0);

        // R10: word and byte pushed together; lane 0 gets the word's byte 0
        dtag = "R10";
        cyc(0, 1, 1, 32'hd4c3b2a1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R11: push and pop on the same lane in one cycle
        dtag = "R11";
        cyc(0, 0, 1, 32'h11, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 32'h22, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 32'h33, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        dtag = "";
        // R3: byte mode fills lane 0 alone
        for (int k = 0; k < 18; k++) cyc(0, 0, 1, 32'(k + 8'h40), 0, 0, 0, 0, 0);
        for (int k = 0; k < 18; k++) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        for (int k = 0; k < 24; k++) cyc(1, 0, 0, 0, 1, 0, 0, 0, 0);

        // R7: serial receive fill in both walks, with overflow
        for (int k = 0; k < 66; k++) cyc(1, 0, 0, 0, 0, 1, 8'(k + 1), 0, 0);
        idle();
        for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 0, 0, 1, 1);  // R10 on read side
        for (int k = 0; k < 14; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 1, 8'(k + 8'h80), 0, 0);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < 20; k++) cyc(1, 0, 0, 0, 0, 0, 0, 1, 0);

        // Random phases alternating fill-heavy and drain-heavy traffic
        for (int ph = 0; ph < 10; ph++) begin
            bit wide = ($urandom % 2) == 1;
            int pp = (ph % 2 == 0) ? 70 : 15;
            int qq = (ph % 2 == 0) ? 15 : 70;
            for (int k = 0; k < 400; k++) begin
                bit pw = ($urandom % 100) < pp / 2;
                bit pb = ($urandom % 100) < pp / 2;
                bit rpw = ($urandom % 100) < qq / 2;
                bit rpb = ($urandom % 100) < qq / 2;
                if (($urandom % 50) == 0) wide = !wide;
                cyc(wide, pw, pb, $urandom, ($urandom % 100) < qq,
                    ($urandom % 100) < pp, 8'($urandom), rpw, rpb);
            end
        end
        idle();
        idle();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule